// File: doc/BRIEF.md
# Microcode Sequencer with Opcode Forcing

This block sequences a microcoded processor. It holds the instruction register (IR) and a 3-bit micro-step counter. It builds the control-store address from the step, the opcode lines and an interrupt flag. It reads a small synthesizable control store and splits the 16-bit control word it returns into its fields. Those fields are the read-bus select, the address-source select, the write-target select and the incrementer select. The word also carries three single-bit strobes, and two of them (IR load and high-pointer load) leave the block undecoded.

Interrupts are taken only at an instruction boundary. When a request is present on the last step of an instruction, the interrupt flag is raised for exactly one cycle. During that cycle the opcode lines sent to the control store are forced to zero, so every interrupt enters the same microcode entry. That entry can load the IR from the write bus. The following steps then run under that loaded opcode with the flag low.

Top module: `mseq_top`

## Requirements
- R1: While reset is low, and at the first sample after it rises, step is 0, the IR is 0x00, the interrupt flag is low and ctrlAddr is 0x000.
- R2: ctrlAddr bits [11:9] carry the step, bits [8:1] the opcode lines and bit [0] the interrupt flag.
- R3: When the word's end bit is set, the step is 0 on the next cycle. Otherwise the step is one greater on the next cycle, so an opcode can use all eight steps 0 to 7.
- R4: With the interrupt flag low, the IR takes dataBus when the IR-load bit is set and keeps its value when that bit is clear, whatever dataBus and writeBus show.
- R5: The interrupt flag rises only in the cycle after a cycle that has both the end bit set and intReq high. It stays high for exactly one cycle, with the step at 0. A request that is present only while the end bit is clear has no effect.
- R6: While the interrupt flag is high, ctrlAddr bits [8:1] are 0x00 even when the IR holds a nonzero value.
- R7: With the interrupt flag high and the IR-load bit set, the IR takes writeBus and not dataBus.
- R8: The control word splits as follows: rdSel = [15:12], adrSel = [11:9], wrSel = [8:5], incSel = [4:3], irLoad = [2], hiPtrLoad = [1], end bit = [0].
- R9: The stored program is as follows. Opcode 0x11 gives step0 = 0x3200 and step1 = 0x0045. Opcode 0x22 gives 0x0010, 0x0002, 0x0A00 and 0x0005 for steps 0 to 3. Opcode 0x33 gives 0x0008 for steps 0 to 6 and 0x0005 for step 7. The interrupt entry (flag high, step 0) gives 0x01C4.
- R10: Every other address, including opcode 0x00 with the flag low, returns 0x0005, which means fetch and end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, sampled on the clock |
| intReq | input | 1 | Interrupt request level |
| dataBus | input | 8 | External data bus, the opcode fetch source |
| writeBus | input | 8 | Internal write bus, the IR source in the interrupt entry |
| step | output | 3 | Current micro-step |
| intActive | output | 1 | Interrupt flag (first interrupt cycle) |
| irValue | output | 8 | Instruction register contents |
| ctrlAddr | output | 12 | Control-store address |
| ctrlWord | output | 16 | Raw control word |
| rdSel | output | 4 | Read-bus source select field |
| adrSel | output | 3 | Address source select field |
| wrSel | output | 4 | Write target select field |
| incSel | output | 2 | Incrementer select field |
| irLoad | output | 1 | IR load strobe, passed through undecoded |
| hiPtrLoad | output | 1 | Pointer high-byte load strobe, passed through undecoded |

## Verification
The assertions assume that intReq, dataBus and writeBus are synchronous to the clock and change only between rising edges. They also assume that reset is held low across at least one rising edge. The bench meets this by driving every input on the falling edge and by holding reset through several rising edges before it releases it. A request is raised only at chosen steps: one lands on a step without the end bit, to show that it is ignored. Another lands on an instruction's final step and is dropped once the interrupt cycle is seen. This prevents a held request from re-entering the interrupt after the handler's end step, which would break the one-cycle expectation.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int STEP_W = 3;
  localparam int OP_W   = 8;
  localparam int WORD_W = 16;
  localparam int ADDR_W = STEP_W + OP_W + 1;

  localparam int RD_W  = 4;
  localparam int ADR_W = 3;
  localparam int WR_W  = 4;
  localparam int INC_W = 2;

  typedef struct packed {
    logic [RD_W-1:0]  rdSel;
    logic [ADR_W-1:0] adrSel;
    logic [WR_W-1:0]  wrSel;
    logic [INC_W-1:0] incSel;
    logic             irLoad;
    logic             hiPtrLoad;
    logic             endInstr;
  } ctrlWord_t;

  // strobes from control to datapath
  typedef struct packed {
    logic irLoad;
    logic irFromWrite;
    logic forceZero;
  } seqStrobe_t;

  localparam logic [WORD_W-1:0] W_FETCH_END = 16'h0005;
  localparam logic [WORD_W-1:0] W_INT_ENTRY = 16'h01C4;
endpackage

// File: rtl/mseq_store.sv
module mseq_store
  import mseq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output ctrlWord_t         word
);
  logic [STEP_W-1:0] q;
  logic [OP_W-1:0]   op;
  logic              intFlag;
  logic [WORD_W-1:0] raw;

  assign q       = addr[ADDR_W-1 -: STEP_W];
  assign op      = addr[OP_W:1];
  assign intFlag = addr[0];

  always_comb begin
    raw = W_FETCH_END;
    if (intFlag) begin
      if (q == '0) raw = W_INT_ENTRY;
    end else begin
      case (op)
        8'h11: begin
          case (q)
            3'd0:    raw = 16'h3200;
            3'd1:    raw = 16'h0045;
            default: raw = W_FETCH_END;
          endcase
        end
        8'h22: begin
          case (q)
            3'd0:    raw = 16'h0010;
            3'd1:    raw = 16'h0002;
            3'd2:    raw = 16'h0A00;
            default: raw = W_FETCH_END;
          endcase
        end
        8'h33: begin
          if (q != 3'd7) raw = 16'h0008;
        end
        default: raw = W_FETCH_END;
      endcase
    end
  end

  assign word = ctrlWord_t'(raw);
endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              intReq,
  input  ctrlWord_t         word,
  output logic [STEP_W-1:0] step,
  output logic              intActive,
  output seqStrobe_t        strobe
);
  logic takeInt;

  assign takeInt = word.endInstr & intReq & ~intActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step      <= '0;
      intActive <= 1'b0;
    end else begin
      step      <= word.endInstr ? '0 : step + 1'b1;
      intActive <= takeInt;
    end
  end

  always_comb begin
    strobe.irLoad      = word.irLoad;
    strobe.irFromWrite = intActive;
    strobe.forceZero   = intActive;
  end
endmodule

// File: rtl/mseq_dpath.sv
module mseq_dpath
  import mseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [STEP_W-1:0] step,
  input  logic              intActive,
  input  logic [OP_W-1:0]   dataBus,
  input  logic [OP_W-1:0]   writeBus,
  output logic [OP_W-1:0]   irValue,
  output logic [ADDR_W-1:0] ctrlAddr
);
  logic [OP_W-1:0] opLines;

  always_ff @(posedge clk) begin
    if (!rstN)             irValue <= '0;
    else if (strobe.irLoad) irValue <= strobe.irFromWrite ? writeBus : dataBus;
  end

  assign opLines  = strobe.forceZero ? '0 : irValue;
  assign ctrlAddr = {step, opLines, intActive};
endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              intReq,
  input  logic [OP_W-1:0]   dataBus,
  input  logic [OP_W-1:0]   writeBus,
  output logic [STEP_W-1:0] step,
  output logic              intActive,
  output logic [OP_W-1:0]   irValue,
  output logic [ADDR_W-1:0] ctrlAddr,
  output logic [WORD_W-1:0] ctrlWord,
  output logic [RD_W-1:0]   rdSel,
  output logic [ADR_W-1:0]  adrSel,
  output logic [WR_W-1:0]   wrSel,
  output logic [INC_W-1:0]  incSel,
  output logic              irLoad,
  output logic              hiPtrLoad
);
  ctrlWord_t  word;
  seqStrobe_t strobe;

  mseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .intReq(intReq), .word(word),
    .step(step), .intActive(intActive), .strobe(strobe)
  );

  mseq_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .step(step),
    .intActive(intActive), .dataBus(dataBus), .writeBus(writeBus),
    .irValue(irValue), .ctrlAddr(ctrlAddr)
  );

  mseq_store u_store (.addr(ctrlAddr), .word(word));

  assign ctrlWord  = word;
  assign rdSel     = word.rdSel;
  assign adrSel    = word.adrSel;
  assign wrSel     = word.wrSel;
  assign incSel    = word.incSel;
  assign irLoad    = word.irLoad;
  assign hiPtrLoad = word.hiPtrLoad;
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk
  import mseq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              intReq,
  input logic [STEP_W-1:0] step,
  input logic              intActive,
  input logic [OP_W-1:0]   irValue,
  input logic [ADDR_W-1:0] ctrlAddr,
  input logic [WORD_W-1:0] ctrlWord,
  input logic              irLoad
);
  // R3: step advances by one when the end bit is clear
  a_r3_step_advance: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWord[0] |=> step == 3'($past(step) + 1'b1));
  // R3: end bit returns the step to zero
  a_r3_step_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord[0] |=> step == '0);
  // R5: interrupt flag lasts one cycle
  a_r5_int_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    intActive |=> !intActive);
  // R5: flag rises only after an end step with a request
  a_r5_int_needs_end: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrlWord[0] && intReq) |=> !intActive);
  // R5: interrupt cycle is at step zero
  a_r5_int_step0: assert property (@(posedge clk) disable iff (!rstN)
    intActive |-> step == '0);
  // R6: opcode lines forced to zero during the interrupt cycle
  a_r6_forced: assert property (@(posedge clk) disable iff (!rstN)
    intActive |-> ctrlAddr[OP_W:1] == '0);
  // R4: IR holds without a load strobe
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    !irLoad |=> $stable(irValue));
endmodule

bind mseq_top mseq_chk u_chk (
  .clk(clk), .rstN(rstN), .intReq(intReq), .step(step),
  .intActive(intActive), .irValue(irValue), .ctrlAddr(ctrlAddr),
  .ctrlWord(ctrlWord), .irLoad(irLoad)
);

// File: tb/mseq_top_bench.sv
`timescale 1ns/1ps
module mseq_top_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic intReq = 1'b0;
  logic [7:0] dataBus = 8'h00;
  logic [7:0] writeBus = 8'h00;
  logic [2:0] step;
  logic intActive;
  logic [7:0] irValue;
  logic [11:0] ctrlAddr;
  logic [15:0] ctrlWord;
  logic [3:0] rdSel;
  logic [2:0] adrSel;
  logic [3:0] wrSel;
  logic [1:0] incSel;
  logic irLoad;
  logic hiPtrLoad;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mseq_top u_mseq_top (
    .clk(clk), .rstN(rstN), .intReq(intReq), .dataBus(dataBus),
    .writeBus(writeBus), .step(step), .intActive(intActive),
    .irValue(irValue), .ctrlAddr(ctrlAddr), .ctrlWord(ctrlWord),
    .rdSel(rdSel), .adrSel(adrSel), .wrSel(wrSel), .incSel(incSel),
    .irLoad(irLoad), .hiPtrLoad(hiPtrLoad)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  function automatic logic [11:0] mkAddr(input logic [2:0] q, input logic [7:0] op, input logic f);
    return {q, op, f};
  endfunction

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) nxt();
    chk("R1 step", step, 0);
    chk("R1 ir", irValue, 0);
    chk("R1 int", intActive, 0);
    chk("R1 addr", ctrlAddr, 0);
    rstN = 1'b1;
    nxt();
    chk("R1 step after release", step, 0);
    chk("R1 addr after release", ctrlAddr, 0);
    chk("R10 default word", ctrlWord, 16'h0005);
  endtask

  task automatic t_twoStep();
    dataBus = 8'h11; writeBus = 8'h99;
    nxt();
    chk("R4 ir from dataBus", irValue, 8'h11);
    chk("R2 addr", ctrlAddr, mkAddr(3'd0, 8'h11, 1'b0));
    chk("R9 op11 q0", ctrlWord, 16'h3200);
    chk("R8 rdSel", rdSel, ctrlWord[15:12]);
    chk("R8 adrSel", adrSel, ctrlWord[11:9]);
    chk("R8 rdSel value", rdSel, 4'd3);
    dataBus = 8'h55; intReq = 1'b1;
    nxt();
    chk("R4 ir held", irValue, 8'h11);
    chk("R3 step inc", step, 3'd1);
    chk("R5 request ignored mid-instruction", intActive, 0);
    chk("R9 op11 q1", ctrlWord, 16'h0045);
    chk("R8 wrSel", wrSel, ctrlWord[8:5]);
    chk("R8 end bit", ctrlWord[0], 1'b1);
    intReq = 1'b0;
    nxt();
    chk("R3 step clear", step, 0);
    chk("R4 ir new fetch", irValue, 8'h55);
    chk("R2 addr op55", ctrlAddr, mkAddr(3'd0, 8'h55, 1'b0));
    chk("R10 unlisted op", ctrlWord, 16'h0005);
    dataBus = 8'h00;
    nxt();
  endtask

  task automatic t_eightStep();
    dataBus = 8'h33;
    nxt();
    dataBus = 8'h00;
    for (int q = 0; q < 7; q++) begin
      chk("R3 step walk", step, q);
      chk("R9 op33 body", ctrlWord, 16'h0008);
      chk("R8 incSel", incSel, ctrlWord[4:3]);
      nxt();
    end
    chk("R3 step 7", step, 3'd7);
    chk("R2 addr q7", ctrlAddr, mkAddr(3'd7, 8'h33, 1'b0));
    chk("R9 op33 q7", ctrlWord, 16'h0005);
    nxt();
    chk("R3 back to 0", step, 0);
    chk("R4 ir refetch", irValue, 8'h00);
  endtask

  task automatic t_interrupt();
    intReq = 1'b1; dataBus = 8'h11; writeBus = 8'h22;
    nxt();
    chk("R5 int high", intActive, 1);
    chk("R5 int step0", step, 0);
    chk("R6 ir nonzero", irValue, 8'h11);
    chk("R6 forced addr", ctrlAddr, mkAddr(3'd0, 8'h00, 1'b1));
    chk("R9 int entry", ctrlWord, 16'h01C4);
    intReq = 1'b0; dataBus = 8'h77;
    nxt();
    chk("R5 int one cycle", intActive, 0);
    chk("R7 ir from writeBus", irValue, 8'h22);
    chk("R2 addr op22 q1", ctrlAddr, mkAddr(3'd1, 8'h22, 1'b0));
    chk("R9 op22 q1", ctrlWord, 16'h0002);
    chk("R8 hiPtrLoad", hiPtrLoad, 1'b1);
    nxt();
    chk("R9 op22 q2", ctrlWord, 16'h0A00);
    chk("R8 adrSel 5", adrSel, 3'd5);
    nxt();
    chk("R9 op22 q3", ctrlWord, 16'h0005);
    chk("R8 irLoad", irLoad, 1'b1);
    nxt();
    chk("R5 no re-entry", intActive, 0);
    chk("R4 ir after handler", irValue, 8'h77);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_twoStep();
    t_eightStep();
    t_interrupt();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule